// File: doc/BRIEF.md
# Change-of-Flow Trace Buffer

This block keeps a short history of where a processor's program has been, so that a debugger can rebuild the recent control flow after the core stops. Each retired instruction's program address is written into the newest slot of a twelve-entry circular array. When the retired instruction changed the flow of control (a jump, branch taken, return and so on), its slot is committed and the next retired address goes into a fresh slot. The array therefore holds the last retired address plus the earlier flow-changing addresses, overwriting the oldest once full. The decoding that decides whether an instruction is flow-changing happens outside this block and arrives as a flag.

When the debug-mode input rises, capture stops and three stage registers latch the live fetch, decode and execute program addresses. The read pointer is set so that a debugger reading the single trace address gets the oldest slot first and the newest last. Every trace read advances the pointer by one, wrapping at twelve, so a complete pass of twelve reads leaves the pointer where it started. Reads of the three stage registers use the same read port and leave the pointer alone.

Top module: `cof_trace_buf`

## Requirements
- R1: After reset `rd_ack` is 0, and all twelve slots are empty.
- R2: Each retire while `dbg_mode` is 0 writes `{1'b1, retire_pc}` into the newest slot. A retire with `retire_cof`=0 replaces that slot on the next retire instead of keeping it.
- R3: A retire with `retire_cof`=1 commits its slot, so the following retire goes into the next slot in the ring. Only the twelve most recent slots are kept; the oldest is overwritten.
- R4: While `dbg_mode` is 1, retires are ignored and the stored history does not change.
- R5: On the cycle `dbg_mode` rises, the read pointer moves to the slot after the newest one. Trace reads then return slots from oldest to newest in retire order.
- R6: A read with `rd_sel`=3 returns the slot at the read pointer and advances the pointer by one modulo 12. Twelve such reads return the pointer to its starting slot.
- R7: A read with `rd_sel`=0, 1 or 2 returns `{1'b0, pc}` for the fetch, decode or execute stage register respectively, and does not move the read pointer.
- R8: The three stage registers load `fetch_pc`, `decode_pc` and `exec_pc` on the cycle `dbg_mode` rises, and hold their values at all other times.
- R9: `rd_ack` is 1 in the cycle after `rd_en` was 1, and 0 otherwise. `rd_data` is valid in that same cycle.
- R10: Bit 24 of a slot is its written flag. A slot never written since reset reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_vld | input | 1 | An instruction retired this cycle |
| retire_pc | input | 24 | Program address of the retired instruction |
| retire_cof | input | 1 | The retired instruction changed the flow of control |
| fetch_pc | input | 24 | Live fetch-stage program address |
| decode_pc | input | 24 | Live decode-stage program address |
| exec_pc | input | 24 | Live execute-stage program address |
| dbg_mode | input | 1 | Core is halted in debug mode; the rising edge is the entry event |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | 0 fetch, 1 decode, 2 execute, 3 trace buffer |
| rd_data | output | 25 | Read result, registered |
| rd_ack | output | 1 | Read result valid |

## Verification
The bench first fills only a few slots and then reads, so a design that puts the pointer at the newest slot or at slot zero returns the empty slots in the wrong place. A non-flow-changing retire right after a debug session must replace the newest slot rather than append; a design with a stale commit flag would keep it and shift the whole history. The bench sends more than twelve flow changes to force the ring to wrap, and reads twice twelve times to show that the pointer comes back to its start. It also mixes stage reads and retires into the debug session: a pointer that moves on stage reads, or capture that keeps running during debug, shows up as a reordered or altered trace sequence.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;

  typedef enum logic [1:0] {
    SEL_FETCH  = 2'd0,
    SEL_DECODE = 2'd1,
    SEL_EXEC   = 2'd2,
    SEL_TRACE  = 2'd3
  } rd_sel_e;

  // Next ring index, wrapping at depth
  function automatic int wrap_inc(input int p, input int depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/cof_trace_ring.sv
module cof_trace_ring
  import cof_trace_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int AW    = 24,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_cof,
  input  logic [PW-1:0] rd_idx,
  output logic [AW:0]   rd_entry,
  output logic [PW-1:0] wr_ptr,
  output logic          commit_step
);

  logic [AW:0]   slots [DEPTH];
  logic          pend;
  logic [PW-1:0] tgt;

  // the previous retire was flow-changing: open a fresh slot
  assign commit_step = wr_en & pend;
  assign tgt         = commit_step ? PW'(wrap_inc(int'(wr_ptr), DEPTH)) : wr_ptr;
  assign rd_entry    = slots[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      pend   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (wr_en) begin
      slots[tgt] <= {1'b1, wr_addr};
      wr_ptr     <= tgt;
      pend       <= wr_cof;
    end
  end

endmodule

// File: rtl/cof_stage_latch.sv
module cof_stage_latch #(
  parameter int AW     = 24,
  parameter int NSTAGE = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap,
  input  logic [NSTAGE*AW-1:0] live,
  output logic [NSTAGE*AW-1:0] held
);

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)   held[s*AW +: AW] <= '0;
      else if (cap) held[s*AW +: AW] <= live[s*AW +: AW];
    end
  end

endmodule

// File: rtl/cof_trace_buf.sv
module cof_trace_buf
  import cof_trace_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int AW    = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire_vld,
  input  logic [AW-1:0] retire_pc,
  input  logic          retire_cof,
  input  logic [AW-1:0] fetch_pc,
  input  logic [AW-1:0] decode_pc,
  input  logic [AW-1:0] exec_pc,
  input  logic          dbg_mode,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  output logic [AW:0]   rd_data,
  output logic          rd_ack
);

  localparam int PW     = $clog2(DEPTH);
  localparam int NSTAGE = 3;

  logic              dbg_q;
  logic              dbg_entry;
  logic              cap_en;
  logic              tb_read;
  logic [PW-1:0]     rd_ptr;
  logic [PW-1:0]     wr_ptr;
  logic              commit_step;
  logic [AW:0]       ring_entry;
  logic [NSTAGE*AW-1:0] stage_q;
  logic [AW-1:0]     stage_sel;
  rd_sel_e           sel;

  assign sel       = rd_sel_e'(rd_sel);
  assign dbg_entry = dbg_mode & ~dbg_q;
  assign cap_en    = retire_vld & ~dbg_mode;
  assign tb_read   = rd_en & (sel == SEL_TRACE);

  cof_trace_ring #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ring (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cap_en),
    .wr_addr     (retire_pc),
    .wr_cof      (retire_cof),
    .rd_idx      (rd_ptr),
    .rd_entry    (ring_entry),
    .wr_ptr      (wr_ptr),
    .commit_step (commit_step)
  );

  cof_stage_latch #(.AW(AW), .NSTAGE(NSTAGE)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (dbg_entry),
    .live  ({exec_pc, decode_pc, fetch_pc}),
    .held  (stage_q)
  );

  always_comb begin
    case (sel)
      SEL_FETCH:  stage_sel = stage_q[0*AW +: AW];
      SEL_DECODE: stage_sel = stage_q[1*AW +: AW];
      SEL_EXEC:   stage_sel = stage_q[2*AW +: AW];
      default:    stage_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_q   <= 1'b0;
      rd_ptr  <= PW'(wrap_inc(0, DEPTH));
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      dbg_q  <= dbg_mode;
      rd_ack <= rd_en;
      if (rd_en) rd_data <= tb_read ? ring_entry : {1'b0, stage_sel};
      if (dbg_entry)    rd_ptr <= PW'(wrap_inc(int'(wr_ptr), DEPTH));
      else if (tb_read) rd_ptr <= PW'(wrap_inc(int'(rd_ptr), DEPTH));
    end
  end

endmodule

// File: rtl/cof_trace_buf_chk.sv
module cof_trace_buf_chk
  import cof_trace_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int AW    = 24,
  parameter int PW    = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_mode,
  input logic              dbg_entry,
  input logic              rd_en,
  input logic              tb_read,
  input logic              rd_ack,
  input logic [PW-1:0]     rd_ptr,
  input logic [PW-1:0]     wr_ptr,
  input logic [3*AW-1:0]   stage_q
);

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_ptr) < DEPTH) && (int'(wr_ptr) < DEPTH)); // R6

  AST_ENTRY_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_entry |=> rd_ptr == PW'(wrap_inc(int'($past(wr_ptr)), DEPTH))); // R5

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_read && !dbg_entry) |=> rd_ptr == PW'(wrap_inc(int'($past(rd_ptr)), DEPTH))); // R6

  AST_STAGE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !tb_read && !dbg_entry) |=> $stable(rd_ptr)); // R7

  AST_DEBUG_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |=> $stable(wr_ptr)); // R4

  AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_entry |=> $stable(stage_q)); // R8

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_ack); // R9

  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_ack); // R9

endmodule

bind cof_trace_buf cof_trace_buf_chk #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dbg_mode  (dbg_mode),
  .dbg_entry (dbg_entry),
  .rd_en     (rd_en),
  .tb_read   (tb_read),
  .rd_ack    (rd_ack),
  .rd_ptr    (rd_ptr),
  .wr_ptr    (wr_ptr),
  .stage_q   (stage_q)
);

// File: tb/cof_trace_buf_test.sv
module cof_trace_buf_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 24;
  localparam int DEPTH = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          retire_vld;
  logic [AW-1:0] retire_pc;
  logic          retire_cof;
  logic [AW-1:0] fetch_pc, decode_pc, exec_pc;
  logic          dbg_mode;
  logic          rd_en;
  logic [1:0]    rd_sel;
  logic [AW:0]   rd_data;
  logic          rd_ack;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [AW-1:0] hist[$];
  logic          m_pend;
  logic          m_dq;
  logic [AW:0]   snap [DEPTH];
  int            k;
  logic [AW-1:0] st [3];
  logic          exp_ack;
  logic [AW:0]   exp_data;

  logic [AW:0]   got [2*DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  cof_trace_buf #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .retire_pc(retire_pc),
    .retire_cof(retire_cof), .fetch_pc(fetch_pc), .decode_pc(decode_pc),
    .exec_pc(exec_pc), .dbg_mode(dbg_mode), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .rd_ack(rd_ack)
  );

  task automatic check(input bit ok, input string req, input logic [AW:0] act, input logic [AW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    hist.delete();
    m_pend = 0; m_dq = 0; k = 0; exp_ack = 0; exp_data = '0;
    for (int i = 0; i < DEPTH; i++) snap[i] = '0;
    for (int i = 0; i < 3; i++) st[i] = '0;
  endtask

  // one clock of the behavioural model, inputs as sampled at the edge
  task automatic model_update();
    bit entry;
    entry = dbg_mode && !m_dq;
    exp_ack = rd_en;
    if (rd_en) begin
      if (rd_sel == 2'd3) begin
        exp_data = snap[k];
        k = (k + 1) % DEPTH;
      end else begin
        exp_data = {1'b0, st[rd_sel]};
      end
    end
    if (entry) begin
      st[0] = fetch_pc; st[1] = decode_pc; st[2] = exec_pc;
      for (int i = 0; i < DEPTH; i++) snap[i] = '0;
      for (int j = 0; j < hist.size(); j++)
        snap[DEPTH - hist.size() + j] = {1'b1, hist[j]};
      k = 0;
    end
    if (retire_vld && !dbg_mode) begin
      if (hist.size() == 0 || m_pend) hist.push_back(retire_pc);
      else hist[hist.size()-1] = retire_pc;
      if (hist.size() > DEPTH) void'(hist.pop_front());
      m_pend = retire_cof;
    end
    m_dq = dbg_mode;
  endtask

  task automatic step(input logic rv, input logic [AW-1:0] ra, input logic rc,
                      input logic dbg, input logic re, input logic [1:0] rs, input string tag);
    retire_vld = rv; retire_pc = ra; retire_cof = rc;
    dbg_mode = dbg; rd_en = re; rd_sel = rs;
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(rd_ack == exp_ack, "R9 ack", {24'd0, rd_ack}, {24'd0, exp_ack});
    if (exp_ack) check(rd_data == exp_data, tag, rd_data, exp_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; retire_vld = 0; retire_pc = '0; retire_cof = 0;
    fetch_pc = '0; decode_pc = '0; exec_pc = '0;
    dbg_mode = 0; rd_en = 0; rd_sel = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rd_ack == 1'b0, "R1 reset ack", {24'd0, rd_ack}, '0);

    // read before anything was captured: empty slot
    step(0, '0, 0, 0, 1, 2'd3, "R10");
    check(rd_data == '0, "R10 empty slot", rd_data, '0);

    // scenario A: few slots, non-flow retire replaces newest
    fetch_pc = 24'h000208; decode_pc = 24'h000206; exec_pc = 24'h000204;
    step(1, 24'h000100, 0, 0, 0, 2'd0, "R2");
    step(1, 24'h000104, 1, 0, 0, 2'd0, "R3");
    step(1, 24'h000200, 0, 0, 0, 2'd0, "R2");
    step(1, 24'h000204, 0, 0, 0, 2'd0, "R2");
    step(0, '0, 0, 1, 0, 2'd0, "R8");      // debug entry
    fetch_pc = 24'hAAAAAA; decode_pc = 24'hBBBBBB; exec_pc = 24'hCCCCCC;
    step(1, 24'h000999, 1, 1, 1, 2'd0, "R7");
    check(rd_data == {1'b0, 24'h000208}, "R8 fetch frozen", rd_data, {1'b0, 24'h000208});
    step(1, 24'h000998, 0, 1, 1, 2'd1, "R7");
    check(rd_data == {1'b0, 24'h000206}, "R8 decode frozen", rd_data, {1'b0, 24'h000206});
    step(0, '0, 0, 1, 1, 2'd2, "R7");
    check(rd_data == {1'b0, 24'h000204}, "R8 exec frozen", rd_data, {1'b0, 24'h000204});
    for (int i = 0; i < 2*DEPTH; i++) begin
      step(0, '0, 0, 1, 1, 2'd3, "R5");
      got[i] = rd_data;
    end
    check(got[0] == '0, "R10 oldest empty", got[0], '0);
    check(got[10] == {1'b1, 24'h000104}, "R3 committed slot", got[10], {1'b1, 24'h000104});
    check(got[11] == {1'b1, 24'h000204}, "R2 newest slot", got[11], {1'b1, 24'h000204});
    check(got[11] != {1'b1, 24'h000999}, "R4 debug retire ignored", got[11], {1'b1, 24'h000204});
    for (int i = 0; i < DEPTH; i++)
      check(got[i+DEPTH] == got[i], "R6 twelve-read wrap", got[i+DEPTH], got[i]);

    // scenario B: leave debug, overflow the ring
    step(0, '0, 0, 0, 0, 2'd0, "R4");
    for (int i = 0; i < 15; i++)
      step(1, 24'h001000 + 24'(4*i), 1, 0, 0, 2'd0, "R3");
    step(1, 24'h002000, 0, 0, 0, 2'd0, "R2");
    step(0, '0, 0, 1, 0, 2'd0, "R5");
    for (int i = 0; i < DEPTH; i++) begin
      step(0, '0, 0, 1, 1, 2'd3, "R5");
      got[i] = rd_data;
      if (i == 4) step(0, '0, 0, 1, 1, 2'd1, "R7");
    end
    check(got[0] == {1'b1, 24'h001010}, "R3 oldest after wrap", got[0], {1'b1, 24'h001010});
    check(got[5] == {1'b1, 24'h001024}, "R7 no advance on stage read", got[5], {1'b1, 24'h001024});
    check(got[11] == {1'b1, 24'h002000}, "R2 newest after wrap", got[11], {1'b1, 24'h002000});
    step(0, '0, 0, 1, 0, 2'd0, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule